// File: doc/BRIEF.md
# Status-Polled Flash Bank Programmer

This block rewrites one byte-wide flash bank from a source buffer without software stepping through the command protocol. After a start pulse it erases the whole bank, reads every location back to confirm the erased value, then programs the bank one byte at a time and reads it all back again against the source. It acts as a bus master on a simple strobe interface, with one write or one read per cycle. Read data returns one cycle after the read strobe.

Every long flash operation is followed by status polling. The block writes the read-status command to the bank base, reads one byte, and checks the ready bit. The number of polls is bounded. A setup-to-data delay before each programmed byte is counted in clock cycles derived from the clock frequency. The result is left on sticky flags (done, timeout, verify failure, captured error bits) until the next start.

Top module: `flash_bank_prog`

## Requirements
- R1: A start pulse while idle raises busy and makes the block write 0x20 and then 0xD0 to address 0 on consecutive cycles.
- R2: Each poll is a write of 0x70 to address 0 followed in the next cycle by a read of address 0. Read data arriving one cycle later with bit 7 set ends the poll loop.
- R3: For byte index i, the block writes 0x40 to address i, issues no bus strobe for CLK_MHZ cycles, writes the source byte to address i, and then polls. The source buffer is addressed by i.
- R4: When POLL_LIMIT consecutive status reads all have bit 7 clear, the timeout flag is set, no further bytes are programmed, no read-back takes place, and the block finishes after the clear/reset pair.
- R5: After each phase's polling ends, the block writes 0x50 and then 0xFF to address 0 on consecutive cycles.
- R6: After erase, every address is read back and must equal 0xFF. The first mismatch sets the verify-failure flag and finishes the run without any programming.
- R7: After programming, every address is read back and compared with the source. The first mismatch sets the verify-failure flag and finishes the run.
- R8: Status bits 5:3 of every status read are OR-ed into the 3-bit error output (errBits[0] is status bit 3). These bits do not stop the run, and start clears them.
- R9: Done, timeout, verify-failure and error outputs hold their values until the next start. A start pulse while busy has no effect.
- R10: The bus never asserts write and read together, and neither strobe is asserted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an erase/program/verify run (sampled while idle) |
| srcAddr | output | ADDR_W | Source buffer byte index |
| srcData | input | 8 | Source buffer byte at srcAddr (combinational) |
| busAddr | output | ADDR_W | Flash bus address |
| busWdata | output | 8 | Flash bus write data |
| busWr | output | 1 | Flash bus write strobe |
| busRd | output | 1 | Flash bus read strobe |
| busRdata | input | 8 | Flash read data, valid the cycle after busRd |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (sticky) |
| timeoutFlag | output | 1 | A poll loop ran out (sticky) |
| verifyFail | output | 1 | Read-back mismatch (sticky) |
| errBits | output | 3 | Captured status error bits 5:3 (sticky) |

## Verification
The sequencer is run against a behavioural flash with several source patterns. An ascending pattern confirms the command order, the setup delay and the poll/read accounting. A pattern made of bytes equal to the command codes (0x20, 0x40, 0x50, 0x70, 0xD0, 0xFF, 0x00) shows that data is never mistaken for control. Fault patterns separate the five ways a run can end: an erase that never reports ready, a byte that never reports ready, a location that will not erase, a byte that programs wrong, and status error bits that must be captured while the run still succeeds. A second start in mid-run checks that a run cannot be restarted while busy.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_READ_MODE   = 8'hFF;
  localparam int         READY_BIT       = 7;
  localparam int         ERR_LO          = 3;
  localparam int         ERR_HI          = 5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ER_SETUP,
    ST_ER_GO,
    ST_PG_SETUP,
    ST_PG_WAIT,
    ST_PG_DATA,
    ST_POLL_CMD,
    ST_POLL_RD,
    ST_POLL_CHK,
    ST_CLR,
    ST_RST,
    ST_VF_RD,
    ST_VF_CHK
  } fbp_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       wr;
    logic       rd;
    logic       srcSel;     // write data from source buffer instead of cmd
    logic       atIdx;      // bus address is byte index instead of base
    logic [7:0] cmd;
    logic       startRun;
    logic       idxClr;
    logic       idxInc;
    logic       pollClr;
    logic       pollInc;
    logic       dlyLoad;
    logic       dlyDec;
    logic       grabStatus;
    logic       setTimeout;
    logic       setVerifyFail;
    logic       setDone;
    logic       setProg;
  } fbp_ctl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic idxLast;
    logic pollExpired;
    logic dlyZero;
    logic statusReady;
    logic cmpMatch;
    logic timedOut;
    logic inProg;
  } fbp_stat_t;

endpackage

// File: rtl/fbp_datapath.sv
module fbp_datapath
  import fbp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int POLL_LIMIT = 1000000,
  parameter int DLY_CYC    = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbp_ctl_t          ctl,
  input  logic [7:0]        srcData,
  input  logic [7:0]        busRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  output logic              busWr,
  output logic              busRd,
  output fbp_stat_t         stat,
  output logic              done,
  output logic              timeoutFlag,
  output logic              verifyFail,
  output logic [2:0]        errBits
);

  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int DLY_W  = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
  localparam logic [ADDR_W-1:0] IDX_LAST  = {ADDR_W{1'b1}};
  localparam logic [POLL_W-1:0] POLL_END  = POLL_W'(POLL_LIMIT);
  localparam logic [DLY_W-1:0]  DLY_START = DLY_W'(DLY_CYC - 1);

  logic [ADDR_W-1:0] idx;
  logic [POLL_W-1:0] pollCnt;
  logic [DLY_W-1:0]  dlyCnt;
  logic              phaseProg;
  logic [7:0]        expectByte;

  // byte index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (ctl.startRun || ctl.idxClr) begin
      idx <= '0;
    end else if (ctl.idxInc) begin
      idx <= idx + 1'b1;
    end
  end

  // poll counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (ctl.pollClr) begin
      pollCnt <= '0;
    end else if (ctl.pollInc && pollCnt != POLL_END) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  // setup-to-data delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (ctl.dlyLoad) begin
      dlyCnt <= DLY_START;
    end else if (ctl.dlyDec && dlyCnt != '0) begin
      dlyCnt <= dlyCnt - 1'b1;
    end
  end

  // phase and sticky result flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseProg   <= 1'b0;
      done        <= 1'b0;
      timeoutFlag <= 1'b0;
      verifyFail  <= 1'b0;
      errBits     <= '0;
    end else if (ctl.startRun) begin
      phaseProg   <= 1'b0;
      done        <= 1'b0;
      timeoutFlag <= 1'b0;
      verifyFail  <= 1'b0;
      errBits     <= '0;
    end else begin
      if (ctl.setProg)       phaseProg   <= 1'b1;
      if (ctl.setDone)       done        <= 1'b1;
      if (ctl.setTimeout)    timeoutFlag <= 1'b1;
      if (ctl.setVerifyFail) verifyFail  <= 1'b1;
      if (ctl.grabStatus)    errBits     <= errBits | busRdata[ERR_HI:ERR_LO];
    end
  end

  assign expectByte = phaseProg ? srcData : 8'hFF;

  // bus drive
  assign busWr    = ctl.wr;
  assign busRd    = ctl.rd;
  assign busAddr  = ctl.atIdx ? idx : '0;
  assign busWdata = ctl.srcSel ? srcData : ctl.cmd;
  assign srcAddr  = idx;

  always_comb begin
    stat.idxLast     = (idx == IDX_LAST);
    stat.pollExpired = (pollCnt == POLL_END);
    stat.dlyZero     = (dlyCnt == '0);
    stat.statusReady = busRdata[READY_BIT];
    stat.cmpMatch    = (busRdata == expectByte);
    stat.timedOut    = timeoutFlag;
    stat.inProg      = phaseProg;
  end

endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
  import fbp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  fbp_stat_t stat,
  output fbp_ctl_t  ctl,
  output logic      busy
);

  fbp_state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.startRun = 1'b1;
          nxt          = ST_ER_SETUP;
        end
      end
      ST_ER_SETUP: begin
        ctl.wr  = 1'b1;
        ctl.cmd = CMD_ERASE_SETUP;
        nxt     = ST_ER_GO;
      end
      ST_ER_GO: begin
        ctl.wr      = 1'b1;
        ctl.cmd     = CMD_ERASE_GO;
        ctl.pollClr = 1'b1;
        nxt         = ST_POLL_CMD;
      end
      ST_PG_SETUP: begin
        ctl.wr      = 1'b1;
        ctl.atIdx   = 1'b1;
        ctl.cmd     = CMD_PROG_SETUP;
        ctl.dlyLoad = 1'b1;
        nxt         = ST_PG_WAIT;
      end
      ST_PG_WAIT: begin
        if (stat.dlyZero) nxt = ST_PG_DATA;
        else              ctl.dlyDec = 1'b1;
      end
      ST_PG_DATA: begin
        ctl.wr      = 1'b1;
        ctl.atIdx   = 1'b1;
        ctl.srcSel  = 1'b1;
        ctl.pollClr = 1'b1;
        nxt         = ST_POLL_CMD;
      end
      ST_POLL_CMD: begin
        ctl.wr  = 1'b1;
        ctl.cmd = CMD_STATUS;
        nxt     = ST_POLL_RD;
      end
      ST_POLL_RD: begin
        ctl.rd      = 1'b1;
        ctl.pollInc = 1'b1;
        nxt         = ST_POLL_CHK;
      end
      ST_POLL_CHK: begin
        ctl.grabStatus = 1'b1;
        if (stat.statusReady) begin
          if (stat.inProg && !stat.idxLast) begin
            ctl.idxInc = 1'b1;
            nxt        = ST_PG_SETUP;
          end else begin
            nxt = ST_CLR;
          end
        end else if (stat.pollExpired) begin
          ctl.setTimeout = 1'b1;
          nxt            = ST_CLR;
        end else begin
          nxt = ST_POLL_CMD;
        end
      end
      ST_CLR: begin
        ctl.wr  = 1'b1;
        ctl.cmd = CMD_CLR_STATUS;
        nxt     = ST_RST;
      end
      ST_RST: begin
        ctl.wr  = 1'b1;
        ctl.cmd = CMD_READ_MODE;
        if (stat.timedOut) begin
          ctl.setDone = 1'b1;
          nxt         = ST_IDLE;
        end else begin
          ctl.idxClr = 1'b1;
          nxt        = ST_VF_RD;
        end
      end
      ST_VF_RD: begin
        ctl.rd    = 1'b1;
        ctl.atIdx = 1'b1;
        nxt       = ST_VF_CHK;
      end
      ST_VF_CHK: begin
        if (!stat.cmpMatch) begin
          ctl.setVerifyFail = 1'b1;
          ctl.setDone       = 1'b1;
          nxt               = ST_IDLE;
        end else if (stat.idxLast) begin
          if (stat.inProg) begin
            ctl.setDone = 1'b1;
            nxt         = ST_IDLE;
          end else begin
            ctl.setProg = 1'b1;
            ctl.idxClr  = 1'b1;
            nxt         = ST_PG_SETUP;
          end
        end else begin
          ctl.idxInc = 1'b1;
          nxt        = ST_VF_RD;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog
  import fbp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int POLL_LIMIT = 1000000,
  parameter int CLK_MHZ    = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [7:0]        srcData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  output logic              busWr,
  output logic              busRd,
  input  logic [7:0]        busRdata,
  output logic              busy,
  output logic              done,
  output logic              timeoutFlag,
  output logic              verifyFail,
  output logic [2:0]        errBits
);

  // one microsecond of setup delay
  localparam int DLY_CYC = (CLK_MHZ < 1) ? 1 : CLK_MHZ;

  fbp_ctl_t  ctl;
  fbp_stat_t stat;

  fbp_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stat (stat),
    .ctl  (ctl),
    .busy (busy)
  );

  fbp_datapath #(
    .ADDR_W    (ADDR_W),
    .POLL_LIMIT(POLL_LIMIT),
    .DLY_CYC   (DLY_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .srcData    (srcData),
    .busRdata   (busRdata),
    .srcAddr    (srcAddr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busWr      (busWr),
    .busRd      (busRd),
    .stat       (stat),
    .done       (done),
    .timeoutFlag(timeoutFlag),
    .verifyFail (verifyFail),
    .errBits    (errBits)
  );

endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              busWr,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              cmdWr,
  input logic              timeoutFlag,
  input logic              verifyFail
);

  assert_erase_open_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && busWr && busWdata == 8'h20 && busAddr == '0));

  assert_erase_pair_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWdata == 8'h20) |=> (busWr && busWdata == 8'hD0 && busAddr == '0));

  assert_poll_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWdata == 8'h70) |=> (busRd && busAddr == '0));

  assert_setup_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWdata == 8'h40) |=> (!busWr && !busRd));

  assert_timeout_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> (cmdWr && busWdata == 8'h50 && busAddr == '0));

  assert_clear_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWdata == 8'h50) |=> (cmdWr && busWdata == 8'hFF && busAddr == '0));

  assert_fail_ends_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(verifyFail) |-> (done && !busy));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_finish_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_no_both_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busWr && !busRd));

endmodule

bind flash_bank_prog fbp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .busWr      (busWr),
  .busRd      (busRd),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .cmdWr      (ctl.wr && !ctl.srcSel),
  .timeoutFlag(timeoutFlag),
  .verifyFail (verifyFail)
);

// File: tb/flash_bank_prog_tb.sv
module flash_bank_prog_tb;

  localparam int AW   = 4;
  localparam int NB   = 1 << AW;
  localparam int PL   = 20;
  localparam int MHZ  = 50;
  localparam int LOGN = 4096;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rstN, start;
  logic [AW-1:0] srcAddr, busAddr;
  logic [7:0]    srcData, busWdata, busRdata;
  logic          busWr, busRd, busy, done, timeoutFlag, verifyFail;
  logic [2:0]    errBits;

  flash_bank_prog #(.ADDR_W(AW), .POLL_LIMIT(PL), .CLK_MHZ(MHZ)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .srcAddr(srcAddr), .srcData(srcData),
    .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr), .busRd(busRd),
    .busRdata(busRdata), .busy(busy), .done(done), .timeoutFlag(timeoutFlag),
    .verifyFail(verifyFail), .errBits(errBits)
  );

  logic [7:0] src [NB];
  assign srcData = src[srcAddr];

  // behavioural flash
  logic [7:0] mem [NB];
  logic       statusMode = 1'b0, expConf = 1'b0, expProg = 1'b0, stuck = 1'b0;
  int         busyCnt = 0;
  logic       eraseStuck = 1'b0;
  int         progStuckIdx = -1, eraseBadIdx = -1, corruptIdx = -1;
  logic [2:0] injErr = 3'b000;

  always @(posedge clk) begin
    if (busyCnt > 0) busyCnt <= busyCnt - 1;
    if (busRd)
      busRdata <= statusMode ? {(busyCnt == 0 && !stuck), 1'b0, injErr, 3'b000}
                             : mem[busAddr];
    if (busWr) begin
      if (expProg) begin
        mem[busAddr] <= (int'(busAddr) == corruptIdx) ? (busWdata ^ 8'h01) : busWdata;
        expProg      <= 1'b0;
        busyCnt      <= 3;
        statusMode   <= 1'b1;
        if (int'(busAddr) == progStuckIdx) stuck <= 1'b1;
      end else if (expConf) begin
        expConf <= 1'b0;
        if (busWdata == 8'hD0) begin
          for (int i = 0; i < NB; i++) mem[i] <= (i == eraseBadIdx) ? 8'h00 : 8'hFF;
          busyCnt    <= 3;
          statusMode <= 1'b1;
          if (eraseStuck) stuck <= 1'b1;
        end
      end else begin
        case (busWdata)
          8'h20: expConf <= 1'b1;
          8'h40: expProg <= 1'b1;
          8'h70: statusMode <= 1'b1;
          8'hFF: begin statusMode <= 1'b0; stuck <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  // bus log
  logic [AW-1:0] wA [LOGN];
  logic [7:0]    wD [LOGN];
  int            wC [LOGN];
  int            wN = 0, rN = 0, cyc = 0;
  int            wB, rB;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (busWr && wN < LOGN) begin
      wA[wN] <= busAddr;
      wD[wN] <= busWdata;
      wC[wN] <= cyc;
      wN     <= wN + 1;
    end
    if (busRd) rN <= rN + 1;
  end

  int total = 0, bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cntData(input logic [7:0] v);
    int n = 0;
    for (int i = wB; i < wN; i++) if (wD[i] == v) n++;
    return n;
  endfunction

  task automatic waitDone();
    int k = 0;
    while (!done && k < 8000) begin
      @(negedge clk);
      k++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL run did not finish actual=0 expected=1");
    end
  endtask

  task automatic kick();
    wB = wN; rB = rN;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic clearFaults();
    eraseStuck = 1'b0; progStuckIdx = -1; eraseBadIdx = -1; corruptIdx = -1; injErr = 3'b000;
  endtask

  task automatic checkTail(input string tag);
    chk({tag, " clear cmd"}, wD[wN-2], 8'h50);
    chk({tag, " reset cmd"}, wD[wN-1], 8'hFF);
    chk({tag, " clear/reset gap"}, wC[wN-1] - wC[wN-2], 1);
    chk({tag, " clear addr"}, wA[wN-2], 0);
  endtask

  task automatic checkMem(input string tag);
    int m = 0;
    for (int i = 0; i < NB; i++) if (mem[i] != src[i]) m++;
    chk({tag, " flash contents mismatches"}, m, 0);
  endtask

  task automatic tReset();
    chk("R10 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R9 reset flags", {timeoutFlag, verifyFail, errBits}, 0);
    chk("R10 reset strobes", {busWr, busRd}, 0);
  endtask

  task automatic tNormal();
    int k = -1;
    for (int i = 0; i < NB; i++) src[i] = 8'(i * 3 + 1);
    kick();
    chk("R1 busy after start", busy, 1);
    waitDone();
    chk("R1 first write", {wA[wB], wD[wB]}, {4'h0, 8'h20});
    chk("R1 second write", {wA[wB+1], wD[wB+1]}, {4'h0, 8'hD0});
    chk("R1 erase pair gap", wC[wB+1] - wC[wB], 1);
    chk("R2 first poll cmd", {wA[wB+2], wD[wB+2]}, {4'h0, 8'h70});
    chk("R2 status reads match poll cmds", rN - rB, cntData(8'h70) + 2 * NB);
    for (int i = wB; i < wN; i++) if (k < 0 && wD[i] == 8'h40) k = i;
    chk("R3 first setup addr", wA[k], 0);
    chk("R3 data write", {wA[k+1], wD[k+1]}, {4'h0, src[0]});
    chk("R3 setup delay", wC[k+1] - wC[k], MHZ + 1);
    chk("R3 setup count", cntData(8'h40), NB);
    checkTail("R5");
    checkMem("R7");
    chk("R7 flags clean", {timeoutFlag, verifyFail, errBits}, 0);
  endtask

  task automatic tCmdLike();
    logic [7:0] pat [8] = '{8'h20, 8'h40, 8'h50, 8'h70, 8'hD0, 8'hFF, 8'h00, 8'h80};
    for (int i = 0; i < NB; i++) src[i] = pat[i % 8] ^ ((i >= 8) ? 8'h00 : 8'h00);
    kick();
    waitDone();
    checkMem("R3 command-valued data");
    chk("R7 command-valued flags", {timeoutFlag, verifyFail}, 0);
  endtask

  task automatic tBusyStart();
    for (int i = 0; i < NB; i++) src[i] = 8'(i * 3 + 1);
    kick();
    repeat (100) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    waitDone();
    chk("R9 start while busy ignored", cntData(8'h20), 1);
    checkMem("R9 run completes");
  endtask

  task automatic tEraseTimeout();
    clearFaults(); eraseStuck = 1'b1;
    kick();
    waitDone();
    chk("R4 erase timeout flag", timeoutFlag, 1);
    chk("R4 poll reads", rN - rB, PL);
    chk("R4 no programming", cntData(8'h40), 0);
    chk("R4 verify flag", verifyFail, 0);
    checkTail("R5 after erase timeout");
    clearFaults();
  endtask

  task automatic tProgTimeout();
    clearFaults(); progStuckIdx = 5;
    for (int i = 0; i < NB; i++) src[i] = 8'(i * 3 + 1);
    kick();
    waitDone();
    chk("R4 program timeout flag", timeoutFlag, 1);
    chk("R4 stop at stuck byte", cntData(8'h40), 6);
    chk("R4 no read-back", rN - rB, cntData(8'h70) + NB);
    checkTail("R5 after program timeout");
    clearFaults();
  endtask

  task automatic tEraseBad();
    clearFaults(); eraseBadIdx = 9;
    kick();
    waitDone();
    chk("R6 verify fail", verifyFail, 1);
    chk("R6 done", done, 1);
    chk("R6 no programming", cntData(8'h40), 0);
    chk("R6 stop at first bad", rN - rB, cntData(8'h70) + 10);
    chk("R6 timeout clear", timeoutFlag, 0);
    clearFaults();
  endtask

  task automatic tProgBad();
    clearFaults(); corruptIdx = 3;
    for (int i = 0; i < NB; i++) src[i] = 8'(i * 3 + 1);
    kick();
    waitDone();
    chk("R7 verify fail", verifyFail, 1);
    chk("R7 all bytes programmed", cntData(8'h40), NB);
    chk("R7 stop at first mismatch", rN - rB, cntData(8'h70) + NB + 4);
    clearFaults();
  endtask

  task automatic tErrBits();
    clearFaults(); injErr = 3'b010;
    for (int i = 0; i < NB; i++) src[i] = 8'(i * 3 + 1);
    kick();
    waitDone();
    chk("R8 error bits captured", errBits, 3'b010);
    chk("R8 run not stopped", {timeoutFlag, verifyFail}, 0);
    checkMem("R8");
    clearFaults();
    kick();
    chk("R8 cleared by start", errBits, 0);
    waitDone();
    chk("R8 clean run", errBits, 0);
    repeat (40) @(negedge clk);
    chk("R9 done holds", done, 1);
    chk("R10 idle strobes", {busWr, busRd}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0;
    for (int i = 0; i < NB; i++) src[i] = 8'h00;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tNormal();
    tCmdLike();
    tBusyStart();
    tEraseTimeout();
    tProgTimeout();
    tEraseBad();
    tProgBad();
    tErrBits();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule